// File: doc/BRIEF.md
# Peripheral Bus Master Cycle Sequencer

This block sits next to the host processor and turns one host request into one complete cycle on a single-master peripheral bus. The request names one of five cycle kinds: board select, interrupt-mask write, interrupt-status read, data read or data write. It also carries a register address and write data. The sequencer then drives the matching active-low strobe through a fixed sequence of time slices. The length of each slice, in clock cycles, comes from the `slice_len` input.

Each cycle runs through these states in order. `ST_LEAD` is the lead slice, with address and data set up and the strobe inactive. `ST_STRB1` is the first strobe slice, which is also the window in which the peripheral may stretch the cycle. `ST_WAITX` is the frozen state, entered only from `ST_STRB1` in a data cycle when `wait_n` is low. `ST_STRB2` is the second strobe slice, and read data is captured at its end. `ST_HOLD` is the slice in which address and data stay valid after the strobe rises. `ST_IDLE` accepts a request.

The transitions are:
- IDLE→LEAD when a request is accepted.
- LEAD→STRB1, STRB2→HOLD and HOLD→IDLE at the end of a slice.
- STRB1→WAITX or STRB1→STRB2 at the end of the window.
- WAITX→STRB2 when `wait_n` is sampled high.

The return to idle raises `done` for one cycle. An 8-bit build (`BUS16`=0) uses only the low data byte and the low four address bits.

Top module: `pbus_cycle_seq`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle. A request is taken on the clock where `req_valid` and `req_ready` are both high. `busy` is high from the next cycle until the cycle ends. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R2: Kind code 0 pulses `sel_n`, 1 pulses `wrmask_n`, 2 pulses `rdirq_n`, 3 pulses `rdd_n` and 4 pulses `wrd_n`. At most one strobe is low at any time. Codes 5 to 7 are accepted and run the full sequence, but pull no strobe low and drive nothing.
- R3: Let L be `slice_len`, where 0 counts as 1, sampled when the request is taken. Without stretching, `busy` is high for L cycles before the strobe falls. The strobe then stays low for 2L cycles, and `busy` stays high for L cycles after the strobe rises, 4L in total. Changing `slice_len` during a cycle has no effect on that cycle.
- R4: For back-to-back requests, the strobe stays high for 2L+1 cycles between two strobe pulses, which is never less than two slices.
- R5: In data cycles (codes 3 and 4), `wait_n` is sampled on the last clock of the first strobe slice. If it is low there, the strobe stays low until the clock at which `wait_n` is sampled high. After that, one further full slice of strobe follows.
- R6: `wait_n` has no effect during select, mask-write and status-read cycles. It also has no effect in a data cycle when it is low only before the strobe or only after the window.
- R7: In data cycles, `bus_addr` shows the request address for the whole busy period without change. In the other cycle kinds, `bus_addr` is 0.
- R8: For write kinds (0, 1, 4), `bus_doe` is high and `bus_dout` equals the request data for the whole busy period, including the slice after the strobe rises. For the other kinds, and when idle, `bus_doe` is 0 and `bus_dout` is 0.
- R9: For read kinds (2, 3), `rd_data` takes the `bus_din` value present on the last clock before the strobe rises. `rd_data` keeps its value across cycles that are not reads.
- R10: With `BUS16`=0, `bus_dout` bits 15:8, `bus_addr` bits 5:4 and `rd_data` bits 15:8 are always 0.
- R11: During reset, all strobes are high, `busy`, `done` and `bus_doe` are 0, `rd_data` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slice_len | input | SLICE_W | Clock cycles per time slice (0 counts as 1) |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | ADDR_W | Register address for data cycles |
| req_wdata | input | DATA_W | Write data or board/mask word |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last captured read value |
| bus_addr | output | ADDR_W | Register address lines |
| bus_dout | output | DATA_W | Data driven toward the bus |
| bus_doe | output | 1 | Data driver enable |
| bus_din | input | DATA_W | Data received from the bus |
| wait_n | input | 1 | Active-low stretch request from the peripheral |
| sel_n | output | 1 | Board select strobe |
| wrmask_n | output | 1 | Interrupt-mask write strobe |
| rdirq_n | output | 1 | Interrupt-status read strobe |
| rdd_n | output | 1 | Data read strobe |
| wrd_n | output | 1 | Data write strobe |

## Verification
The bench checks where `wait_n` is sampled. It pulls the line low from the strobe's fall and releases it at several points, so a design that sampled one clock early or late would produce a strobe of the wrong length. It also holds `wait_n` low in non-data cycles, before the strobe and after the window. A design that froze there would produce a longer strobe. The bench changes `bus_din` just after the strobe falls and again after it rises, which exposes capture on the wrong edge. It also runs back-to-back requests to measure the strobe-off gap, and it changes `slice_len` in the middle of a cycle.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int KIND_W    = 3;
    localparam int NUM_KINDS = 5;

    localparam logic [KIND_W-1:0] K_SEL    = 3'd0;
    localparam logic [KIND_W-1:0] K_WRMASK = 3'd1;
    localparam logic [KIND_W-1:0] K_RDIRQ  = 3'd2;
    localparam logic [KIND_W-1:0] K_RDDATA = 3'd3;
    localparam logic [KIND_W-1:0] K_WRDATA = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_STRB1,
        ST_WAITX,
        ST_STRB2,
        ST_HOLD
    } seq_state_e;

    function automatic logic kind_is_write(input logic [KIND_W-1:0] k);
        return (k == K_SEL) || (k == K_WRMASK) || (k == K_WRDATA);
    endfunction

    function automatic logic kind_is_read(input logic [KIND_W-1:0] k);
        return (k == K_RDIRQ) || (k == K_RDDATA);
    endfunction

    function automatic logic kind_is_data(input logic [KIND_W-1:0] k);
        return (k == K_RDDATA) || (k == K_WRDATA);
    endfunction

endpackage

// File: rtl/pbus_slice_tmr.sv
module pbus_slice_tmr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clr,
    input  logic [CNT_W-1:0] len_in,
    output logic             last
);

    logic [CNT_W-1:0] len_m1;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_m1 <= '0;
            cnt    <= '0;
        end else begin
            if (load) begin
                len_m1 <= (len_in == '0) ? '0 : len_in - 1'b1;
            end
            if (clr || last) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign last = (cnt == len_m1);

endmodule

// File: rtl/pbus_strobe_dec.sv
module pbus_strobe_dec
    import pbus_pkg::*;
#(
    parameter int N = NUM_KINDS
) (
    input  logic              active,
    input  logic [KIND_W-1:0] kind,
    output logic [N-1:0]      strb_n
);

    for (genvar k = 0; k < N; k++) begin : g_strb
        assign strb_n[k] = ~(active && (kind == KIND_W'(k)));
    end

endmodule

// File: rtl/pbus_rd_capture.sv
module pbus_rd_capture #(
    parameter int W      = 16,
    parameter int USED_W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    logic [W-1:0] din_used;

    if (USED_W < W) begin : g_narrow
        assign din_used = {{(W-USED_W){1'b0}}, din[USED_W-1:0]};
    end else begin : g_full
        assign din_used = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (cap) begin
            q <= din_used;
        end
    end

endmodule

// File: rtl/pbus_cycle_seq.sv
module pbus_cycle_seq
    import pbus_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 6,
    parameter int SLICE_W = 8,
    parameter int BUS16   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SLICE_W-1:0] slice_len,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [KIND_W-1:0]  req_kind,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_dout,
    output logic               bus_doe,
    input  logic [DATA_W-1:0]  bus_din,
    input  logic               wait_n,
    output logic               sel_n,
    output logic               wrmask_n,
    output logic               rdirq_n,
    output logic               rdd_n,
    output logic               wrd_n
);

    localparam int DUSE = (BUS16 != 0) ? DATA_W : DATA_W / 2;
    localparam int AUSE = (BUS16 != 0) ? ADDR_W : ADDR_W - 2;
    localparam logic [DATA_W-1:0] DKEEP = {DATA_W{1'b1}} >> (DATA_W - DUSE);
    localparam logic [ADDR_W-1:0] AKEEP = {ADDR_W{1'b1}} >> (ADDR_W - AUSE);

    seq_state_e            state, nxt;
    logic [KIND_W-1:0]     kind_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [DATA_W-1:0]     wdata_q;
    logic                  done_q;
    logic                  accept;
    logic                  slice_last;
    logic                  strobe_on;
    logic [NUM_KINDS-1:0]  strb_n;

    assign accept = req_valid && (state == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // request capture and completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (accept) begin
                kind_q  <= req_kind;
                addr_q  <= req_addr & AKEEP;
                wdata_q <= req_wdata & DKEEP;
            end
            done_q <= (state == ST_HOLD) && slice_last;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid)  nxt = ST_LEAD;
            ST_LEAD:  if (slice_last) nxt = ST_STRB1;
            ST_STRB1: if (slice_last) begin
                          nxt = (kind_is_data(kind_q) && !wait_n) ? ST_WAITX : ST_STRB2;
                      end
            ST_WAITX: if (wait_n)     nxt = ST_STRB2;
            ST_STRB2: if (slice_last) nxt = ST_HOLD;
            ST_HOLD:  if (slice_last) nxt = ST_IDLE;
            default:                  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        req_ready = (state == ST_IDLE);
        strobe_on = (state == ST_STRB1) || (state == ST_WAITX) || (state == ST_STRB2);
        bus_doe   = busy && kind_is_write(kind_q);
        bus_addr  = (busy && kind_is_data(kind_q)) ? addr_q : '0;
        bus_dout  = bus_doe ? wdata_q : '0;
        done      = done_q;
    end

    pbus_slice_tmr #(
        .CNT_W (SLICE_W)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .clr    ((state == ST_IDLE) || (state == ST_WAITX)),
        .len_in (slice_len),
        .last   (slice_last)
    );

    pbus_strobe_dec #(
        .N (NUM_KINDS)
    ) u_dec (
        .active (strobe_on),
        .kind   (kind_q),
        .strb_n (strb_n)
    );

    pbus_rd_capture #(
        .W      (DATA_W),
        .USED_W (DUSE)
    ) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   ((state == ST_STRB2) && slice_last && kind_is_read(kind_q)),
        .din   (bus_din),
        .q     (rd_data)
    );

    assign sel_n    = strb_n[K_SEL];
    assign wrmask_n = strb_n[K_WRMASK];
    assign rdirq_n  = strb_n[K_RDIRQ];
    assign rdd_n    = strb_n[K_RDDATA];
    assign wrd_n    = strb_n[K_WRDATA];

endmodule

// File: rtl/pbus_cycle_seq_chk.sv
module pbus_cycle_seq_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              busy,
    input logic              done,
    input logic              bus_doe,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_dout,
    input logic              sel_n,
    input logic              wrmask_n,
    input logic              rdirq_n,
    input logic              rdd_n,
    input logic              wrd_n
);

    logic [4:0] strb;
    assign strb = ~{wrd_n, rdd_n, rdirq_n, wrmask_n, sel_n};

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb));

    a_r2_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (strb == 5'b0));

    a_r1_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_quiet_at_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (strb == 5'b0));

    a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdirq_n || !rdd_n) |-> !bus_doe);

    a_r8_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_doe);

    a_r8_drive_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wrd_n) || $rose(sel_n) || $rose(wrmask_n)) |-> bus_doe);

    a_r7_addr_stable_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdd_n && $past(!rdd_n)) |-> $stable(bus_addr));

    a_r7_addr_stable_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrd_n && $past(!wrd_n)) |-> $stable(bus_addr));

    a_r8_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrd_n && $past(!wrd_n)) |-> $stable(bus_dout));

endmodule

bind pbus_cycle_seq pbus_cycle_seq_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .bus_doe   (bus_doe),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .sel_n     (sel_n),
    .wrmask_n  (wrmask_n),
    .rdirq_n   (rdirq_n),
    .rdd_n     (rdd_n),
    .wrd_n     (wrd_n)
);

// File: tb/pbus_cycle_seq_test.sv
module pbus_cycle_seq_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [7:0]  slice_len;
    logic        req_valid;
    logic [2:0]  req_kind;
    logic [5:0]  req_addr;
    logic [15:0] req_wdata;
    logic [15:0] bus_din;
    logic        wait_n;
    logic        req_ready, busy, done, bus_doe;
    logic [15:0] rd_data, bus_dout;
    logic [5:0]  bus_addr;
    logic        sel_n, wrmask_n, rdirq_n, rdd_n, wrd_n;

    logic [7:0]  slice8;
    logic        req_valid8;
    logic [2:0]  req_kind8;
    logic [5:0]  req_addr8;
    logic [15:0] req_wdata8, bus_din8;
    logic        wait8_n;
    logic        req_ready8, busy8, done8, bus_doe8;
    logic [15:0] rd_data8, bus_dout8;
    logic [5:0]  bus_addr8;
    logic        sel8_n, wrmask8_n, rdirq8_n, rdd8_n, wrd8_n;

    int n_chk = 0;
    int n_fail = 0;

    pbus_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .slice_len(slice_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .wait_n(wait_n),
        .sel_n(sel_n), .wrmask_n(wrmask_n), .rdirq_n(rdirq_n),
        .rdd_n(rdd_n), .wrd_n(wrd_n)
    );

    pbus_cycle_seq #(.BUS16(0)) uut8 (
        .clk(clk), .rst_n(rst_n), .slice_len(slice8),
        .req_valid(req_valid8), .req_ready(req_ready8), .req_kind(req_kind8),
        .req_addr(req_addr8), .req_wdata(req_wdata8),
        .busy(busy8), .done(done8), .rd_data(rd_data8),
        .bus_addr(bus_addr8), .bus_dout(bus_dout8), .bus_doe(bus_doe8),
        .bus_din(bus_din8), .wait_n(wait8_n),
        .sel_n(sel8_n), .wrmask_n(wrmask8_n), .rdirq_n(rdirq8_n),
        .rdd_n(rdd8_n), .wrd_n(wrd8_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // One complete cycle on uut, observed at falling edges.
    task automatic run_cycle(input logic [2:0] kind, input logic [5:0] addr,
                             input logic [15:0] wd, input logic [15:0] dind,
                             input int len, input int exp_lo, input int wf, input int wt,
                             input bit wpre, input bit scramble, input string tag);
        int L = (len == 0) ? 1 : len;
        int busy_cnt = 0, lo_cnt = 0, lead_cnt = 0, hold_cnt = 0;
        int addr_bad = 0, drv_bad = 0, oh_bad = 0, rdy_bad = 0, rel = 0;
        bit seen_lo = 0, seen_done = 0, lo;
        logic [4:0]  s, lo_vec = 5'h1F;
        logic [4:0]  exp_vec = (kind < 3'd5) ? ~(5'b1 << kind) : 5'h1F;
        logic [15:0] prev_rd = rd_data;
        bit is_wr = (kind == 3'd0) || (kind == 3'd1) || (kind == 3'd4);
        bit is_rd = (kind == 3'd2) || (kind == 3'd3);
        logic [5:0]  exp_addr = ((kind == 3'd3) || (kind == 3'd4)) ? addr : 6'h0;
        slice_len = 8'(len);
        req_kind = kind; req_addr = addr; req_wdata = wd;
        req_valid = 1'b1; bus_din = 16'hDEAD;
        wait_n = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            s  = {wrd_n, rdd_n, rdirq_n, wrmask_n, sel_n};
            lo = (s != 5'h1F);
            if (!$onehot0(~s)) oh_bad++;
            if (done) begin
                seen_done = 1;
                check(!busy && req_ready, "R1 idle and ready at done", {busy, req_ready}, 1);
                break;
            end
            if (busy) busy_cnt++;
            if (busy && req_ready) rdy_bad++;
            if (busy && bus_addr != exp_addr) addr_bad++;
            if (busy && ((bus_doe != is_wr) || (bus_dout != (is_wr ? wd : 16'h0)))) drv_bad++;
            if (seen_lo) rel++;
            if (lo) begin
                lo_cnt++;
                lo_vec = s;
                if (!seen_lo) begin seen_lo = 1; rel = 0; end
            end else if (busy) begin
                if (seen_lo) hold_cnt++; else lead_cnt++;
            end
            if (seen_lo) begin
                wait_n = !((rel >= wf) && (rel < wt));
                if (lo && rel == 0) bus_din = dind;
                else if (!lo) bus_din = 16'hBEEF;
            end else begin
                wait_n = !wpre;
            end
            if (scramble && i == 0) slice_len = 8'd9;
            @(negedge clk);
        end
        wait_n = 1'b1;
        check(seen_done, {tag, " R1 done seen"}, seen_done, 1);
        check(rdy_bad == 0, "R1 ready low while busy", rdy_bad, 0);
        check(oh_bad == 0, "R2 one strobe at a time", oh_bad, 0);
        check(lo_vec == exp_vec, {tag, " R2 strobe identity"}, lo_vec, exp_vec);
        check(lead_cnt == ((kind < 3'd5) ? L : 4 * L), {tag, " R3 lead length"}, lead_cnt, (kind < 3'd5) ? L : 4 * L);
        check(lo_cnt == exp_lo, {tag, " strobe low length"}, lo_cnt, exp_lo);
        check(hold_cnt == ((kind < 3'd5) ? L : 0), {tag, " R3 hold length"}, hold_cnt, (kind < 3'd5) ? L : 0);
        check(busy_cnt == 2 * L + exp_lo + ((kind < 3'd5) ? 0 : 2 * L), {tag, " R3 busy length"}, busy_cnt, 2 * L + exp_lo);
        check(addr_bad == 0, {tag, " R7 address lines"}, addr_bad, 0);
        check(drv_bad == 0, {tag, " R8 data drive"}, drv_bad, 0);
        check(rd_data == (is_rd ? dind : prev_rd), {tag, " R9 read value"}, rd_data, is_rd ? dind : prev_rd);
        @(negedge clk);
        check(!done, {tag, " R1 done one cycle"}, done, 0);
    endtask

    task automatic t_reset();
        check({sel_n, wrmask_n, rdirq_n, rdd_n, wrd_n} == 5'h1F, "R11 strobes high", {sel_n, wrmask_n, rdirq_n, rdd_n, wrd_n}, 5'h1F);
        check(!busy && !done && !bus_doe, "R11 busy done doe low", {busy, done, bus_doe}, 0);
        check(rd_data == 16'h0, "R11 rd_data zero", rd_data, 0);
        check(req_ready, "R11 ready", req_ready, 1);
    endtask

    task automatic t_basic();
        run_cycle(3'd0, 6'h2A, 16'hFFFB, 16'h0,    2, 4, 0, 0, 0, 0, "R2 select");
        run_cycle(3'd1, 6'h15, 16'h00F0, 16'h0,    2, 4, 0, 0, 0, 0, "R8 mask");
        run_cycle(3'd3, 6'h2C, 16'h0,    16'hA55A, 2, 4, 0, 0, 0, 0, "R9 data read");
        run_cycle(3'd2, 6'h3F, 16'h0,    16'hFFEF, 2, 4, 0, 0, 0, 0, "R9 status read");
        run_cycle(3'd4, 6'h07, 16'h8001, 16'h0,    2, 4, 0, 0, 0, 0, "R7 data write");
    endtask

    task automatic t_kind_bad();
        run_cycle(3'd5, 6'h01, 16'h1111, 16'h0, 1, 0, 0, 0, 0, 0, "R2 code5");
        run_cycle(3'd7, 6'h02, 16'h2222, 16'h0, 2, 0, 0, 0, 0, 0, "R2 code7");
    endtask

    task automatic t_lengths();
        run_cycle(3'd3, 6'h01, 16'h0,    16'h1357, 0, 2, 0, 0, 0, 0, "R3 zero length");
        run_cycle(3'd4, 6'h3E, 16'h2468, 16'h0,    3, 6, 0, 0, 0, 1, "R3 length sampled");
    endtask

    task automatic t_wait_freeze();
        run_cycle(3'd3, 6'h11, 16'h0,    16'h0F0F, 2, 8, 0, 5, 0, 0, "R5 freeze read");
        run_cycle(3'd4, 6'h22, 16'h7777, 16'h0,    3, 7, 0, 3, 0, 0, "R5 shortest freeze write");
    endtask

    task automatic t_wait_ignored();
        run_cycle(3'd0, 6'h0A, 16'hFFFE, 16'h0,    2, 4, 0, 10, 0, 0, "R6 select");
        run_cycle(3'd1, 6'h0B, 16'h0003, 16'h0,    2, 4, 0, 10, 0, 0, "R6 mask");
        run_cycle(3'd2, 6'h0C, 16'h0,    16'h5AA5, 2, 4, 0, 10, 0, 0, "R6 status");
        run_cycle(3'd3, 6'h0D, 16'h0,    16'hC3C3, 2, 4, 0, 0,  1, 0, "R6 wait before strobe");
        run_cycle(3'd3, 6'h0E, 16'h0,    16'h3C3C, 2, 4, 2, 6,  0, 0, "R6 wait after window");
    endtask

    task automatic t_b2b();
        int gap = 0, last_gap = -1, dones = 0, lows = 0;
        bit was_lo = 0, lo;
        logic [4:0] s, first_vec = 5'h1F, second_vec = 5'h1F;
        slice_len = 8'd2;
        req_kind = 3'd4; req_addr = 6'h05; req_wdata = 16'h1234; req_valid = 1'b1;
        @(negedge clk);
        req_kind = 3'd3; req_addr = 6'h09; bus_din = 16'h4321;
        for (int i = 0; i < 200 && dones < 2; i++) begin
            s  = {wrd_n, rdd_n, rdirq_n, wrmask_n, sel_n};
            lo = (s != 5'h1F);
            if (lo && !was_lo) begin
                lows++;
                if (lows == 2) last_gap = gap;
            end
            if (lo && lows == 1) first_vec = s;
            if (lo && lows == 2) second_vec = s;
            if (!lo && lows == 1) gap++;
            if (done) begin
                dones++;
                req_valid = (dones == 1);
            end else if (dones == 1) begin
                req_valid = 1'b0;
            end
            was_lo = lo;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(dones == 2, "R1 two back-to-back completions", dones, 2);
        check(last_gap == 5, "R4 strobe-off gap", last_gap, 5);
        check(first_vec == 5'b01111 && second_vec == 5'b10111, "R2 back-to-back strobes", {first_vec, second_vec}, 10'h1F7);
        check(rd_data == 16'h4321, "R9 back-to-back read", rd_data, 16'h4321);
        @(negedge clk);
    endtask

    task automatic t_narrow();
        int bad = 0;
        slice8 = 8'd1;
        req_kind8 = 3'd4; req_addr8 = 6'h3F; req_wdata8 = 16'hFFFF; req_valid8 = 1'b1;
        @(negedge clk);
        req_valid8 = 1'b0;
        for (int i = 0; i < 100 && !done8; i++) begin
            if (!wrd8_n && (bus_addr8 != 6'h0F || bus_dout8 != 16'h00FF)) bad++;
            @(negedge clk);
        end
        check(done8, "R10 narrow write done", done8, 1);
        check(bad == 0, "R10 narrow write lines", bad, 0);
        req_kind8 = 3'd3; req_addr8 = 6'h32; bus_din8 = 16'hFFFF; req_valid8 = 1'b1;
        @(negedge clk);
        req_valid8 = 1'b0;
        bad = 0;
        for (int i = 0; i < 100 && !done8; i++) begin
            if (!rdd8_n && bus_addr8 != 6'h02) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R10 narrow read address", bad, 0);
        check(rd_data8 == 16'h00FF, "R10 narrow read value", rd_data8, 16'h00FF);
    endtask

    initial begin
        slice_len = 8'd2; req_valid = 1'b0; req_kind = 3'd0; req_addr = 6'h0;
        req_wdata = 16'h0; bus_din = 16'h0; wait_n = 1'b1;
        slice8 = 8'd1; req_valid8 = 1'b0; req_kind8 = 3'd0; req_addr8 = 6'h0;
        req_wdata8 = 16'h0; bus_din8 = 16'h0; wait8_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !busy, "R1 ready after reset", req_ready, 1);
        t_basic();
        t_kind_bad();
        t_lengths();
        t_wait_freeze();
        t_wait_ignored();
        t_b2b();
        t_narrow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule